// File: doc/BRIEF.md
# Sixteen-Function Combinational ALU

This block is a stateless arithmetic and logic unit. It takes two operands of equal width and a 4-bit function code, and it returns a result of the same width together with a carry-out. It offers sixteen operations: four arithmetic forms of addition and subtraction, six bitwise logic forms, two inversions, two two's-complement negations and two pass-through paths. A carry-in joins the arithmetic path for the add-with-carry and subtract-with-borrow forms.

The unit has no clock and holds no state. The result follows the inputs within the same cycle. The surrounding datapath owns the operand registers, the result register and the sequencing of function codes. Every arithmetic operation goes through a single shared adder. Subtraction and negation are formed by inverting one adder input and choosing the carry into the adder.

Top module: `fn16_alu`

## Requirements
- R1: Code 0 gives result = opa + opb + carry_in, and carry_out is the carry out of the top bit.
- R2: Code 1 gives result = opa + opb + 1, and carry_out is the carry out of the top bit. carry_in has no effect.
- R3: Code 2 gives result = opa − opb, computed as opa + ~opb + 1. carry_out is 1 exactly when opa ≥ opb (unsigned). carry_in has no effect.
- R4: Code 3 gives result = opa + ~opb + carry_in. With carry_in = 0 this is opa − opb − 1, and carry_out is the carry of that sum.
- R5: Codes 4, 5, 12 and 13 give opa AND opb, opa OR opb, opa XOR opb and NOT(opa XOR opb), each with carry_out = 0.
- R6: Code 10 gives (NOT opa) AND opb and code 11 gives opa AND (NOT opb), each with carry_out = 0.
- R7: Code 6 gives NOT opa and code 7 gives NOT opb, each with carry_out = 0.
- R8: Code 8 gives (NOT opa) + 1 and code 9 gives (NOT opb) + 1. carry_out is 1 exactly when the negated operand is zero. carry_in has no effect.
- R9: Code 14 passes opa and code 15 passes opb unchanged, each with carry_out = 0.
- R10: carry_in has no effect on any code other than 0 and 3.
- R11: The outputs follow a change on any input with no clock edge in between, because the unit holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| func_sel | input | 4 | Function code, 0 to 15 |
| carry_in | input | 1 | Carry into the adder for codes 0 and 3 |
| result | output | WIDTH | Selected function result |
| carry_out | output | 1 | Adder carry for arithmetic codes; 0 otherwise |

## Verification
The bench builds the unit with WIDTH = 8. At that width, operand values such as 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF sit close together. Crossing them under every function code, with both carry-in values, reaches every carry and borrow boundary. It also reaches the zero-operand negation, where carry_out rises. The narrow width keeps the full grid of code, operand pair and carry-in to a few thousand vectors.

// File: rtl/fn16_alu_pkg.sv
package fn16_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD     = 4'd0,
        OP_ADD1    = 4'd1,
        OP_SUB     = 4'd2,
        OP_SUBB    = 4'd3,
        OP_AND     = 4'd4,
        OP_OR      = 4'd5,
        OP_NOTA    = 4'd6,
        OP_NOTB    = 4'd7,
        OP_NEGA    = 4'd8,
        OP_NEGB    = 4'd9,
        OP_NAANDB  = 4'd10,
        OP_AANDNB  = 4'd11,
        OP_XOR     = 4'd12,
        OP_XNOR    = 4'd13,
        OP_PASSA   = 4'd14,
        OP_PASSB   = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        YS_OPB  = 2'd0,
        YS_NOTB = 2'd1,
        YS_NOTA = 2'd2
    } y_src_e;

    typedef enum logic [1:0] {
        CS_ZERO = 2'd0,
        CS_ONE  = 2'd1,
        CS_EXT  = 2'd2
    } c_src_e;

    typedef struct packed {
        logic   arith;
        logic   x_zero;
        y_src_e y_src;
        c_src_e c_src;
    } adder_ctl_t;

endpackage

// File: rtl/fn16_alu_decode.sv
module fn16_alu_decode
    import fn16_alu_pkg::*;
(
    input  logic [3:0] func_sel,
    output adder_ctl_t ctl
);

    adder_ctl_t ctl_d;

    always_comb begin
        ctl_d = '{arith: 1'b0, x_zero: 1'b0, y_src: YS_OPB, c_src: CS_ZERO};
        unique case (alu_op_e'(func_sel))
            OP_ADD:  ctl_d = '{arith: 1'b1, x_zero: 1'b0, y_src: YS_OPB,  c_src: CS_EXT};
            OP_ADD1: ctl_d = '{arith: 1'b1, x_zero: 1'b0, y_src: YS_OPB,  c_src: CS_ONE};
            OP_SUB:  ctl_d = '{arith: 1'b1, x_zero: 1'b0, y_src: YS_NOTB, c_src: CS_ONE};
            OP_SUBB: ctl_d = '{arith: 1'b1, x_zero: 1'b0, y_src: YS_NOTB, c_src: CS_EXT};
            OP_NEGA: ctl_d = '{arith: 1'b1, x_zero: 1'b1, y_src: YS_NOTA, c_src: CS_ONE};
            OP_NEGB: ctl_d = '{arith: 1'b1, x_zero: 1'b1, y_src: YS_NOTB, c_src: CS_ONE};
            default: ctl_d = '{arith: 1'b0, x_zero: 1'b0, y_src: YS_OPB,  c_src: CS_ZERO};
        endcase
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/fn16_alu_adder.sv
module fn16_alu_adder
    import fn16_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    input  adder_ctl_t       ctl,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int SW = WIDTH + 1;

    logic [WIDTH-1:0] x_d;
    logic [WIDTH-1:0] y_d;
    logic             c_d;
    logic [SW-1:0]    total_d;

    always_comb begin
        x_d = ctl.x_zero ? '0 : opa;
        unique case (ctl.y_src)
            YS_NOTB: y_d = ~opb;
            YS_NOTA: y_d = ~opa;
            default: y_d = opb;
        endcase
        unique case (ctl.c_src)
            CS_ONE:  c_d = 1'b1;
            CS_EXT:  c_d = carry_in;
            default: c_d = 1'b0;
        endcase
        total_d = {1'b0, x_d} + {1'b0, y_d} + {{WIDTH{1'b0}}, c_d};
    end

    assign sum  = total_d[WIDTH-1:0];
    assign cout = total_d[SW-1];

endmodule

// File: rtl/fn16_alu_logic.sv
module fn16_alu_logic
    import fn16_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [3:0]       func_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] res
);

    logic [WIDTH-1:0] res_d;

    always_comb begin
        unique case (alu_op_e'(func_sel))
            OP_AND:    res_d = opa & opb;
            OP_OR:     res_d = opa | opb;
            OP_NOTA:   res_d = ~opa;
            OP_NOTB:   res_d = ~opb;
            OP_NAANDB: res_d = ~opa & opb;
            OP_AANDNB: res_d = opa & ~opb;
            OP_XOR:    res_d = opa ^ opb;
            OP_XNOR:   res_d = ~(opa ^ opb);
            OP_PASSA:  res_d = opa;
            OP_PASSB:  res_d = opb;
            default:   res_d = '0;
        endcase
    end

    assign res = res_d;

endmodule

// File: rtl/fn16_alu.sv
module fn16_alu
    import fn16_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       func_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    adder_ctl_t       ctl;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] logic_res;

    fn16_alu_decode u_decode (
        .func_sel (func_sel),
        .ctl      (ctl)
    );

    fn16_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .opa      (opa),
        .opb      (opb),
        .carry_in (carry_in),
        .ctl      (ctl),
        .sum      (sum),
        .cout     (cout)
    );

    fn16_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .func_sel (func_sel),
        .opa      (opa),
        .opb      (opb),
        .res      (logic_res)
    );

    logic [WIDTH-1:0] result_d;
    logic             carry_d;

    always_comb begin
        result_d = ctl.arith ? sum : logic_res;
        carry_d  = ctl.arith & cout;
    end

    assign result    = result_d;
    assign carry_out = carry_d;

endmodule

// File: rtl/fn16_alu_chk.sv
module fn16_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [3:0]       func_sel,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);

    logic [WIDTH:0] add_ref;
    logic [WIDTH-1:0] sub_back;
    logic [WIDTH-1:0] nega_back;

    always_comb begin
        add_ref   = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
        sub_back  = result + opb;
        nega_back = result + opa;
        if (!$isunknown({opa, opb, func_sel, carry_in})) begin
            if (func_sel == 4'd0) begin
                // R1
                add_carry_chk: assert ({carry_out, result} == add_ref);
            end
            if (func_sel == 4'd2) begin
                // R3
                sub_inverse_chk: assert (sub_back == opa && carry_out == (opa >= opb));
            end
            if (func_sel == 4'd8) begin
                // R8
                neg_zero_sum_chk: assert (nega_back == '0 && carry_out == (opa == '0));
            end
            if (func_sel == 4'd14) begin
                // R9
                pass_a_chk: assert (result == opa && !carry_out);
            end
            if (func_sel == 4'd12 || func_sel == 4'd13) begin
                // R5
                xor_pair_chk: assert (((result ^ opa ^ opb) == '0) == (func_sel == 4'd12) && !carry_out);
            end
        end
    end

endmodule

bind fn16_alu fn16_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .func_sel  (func_sel),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/fn16_alu_bench.sv
module fn16_alu_bench;

    localparam int BW = 8;
    localparam int WATCHDOG_CYCLES = 100000;

    logic          clk = 1'b0;
    logic [BW-1:0] opa = '0;
    logic [BW-1:0] opb = '0;
    logic [3:0]    func_sel = 4'd0;
    logic          carry_in = 1'b0;
    logic [BW-1:0] result;
    logic          carry_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fn16_alu #(.WIDTH(BW)) u_fn16_alu (
        .opa       (opa),
        .opb       (opb),
        .func_sel  (func_sel),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic logic [BW-1:0] corner(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h7F;
            3: return 8'h80;
            4: return 8'hFE;
            5: return 8'hFF;
            6: return 8'h5A;
            7: return 8'h33;
            default: return 8'hC4;
        endcase
    endfunction

    // Expected {carry_out, result} written from the requirement list.
    function automatic logic [BW:0] expect_of(input int op, input logic [BW-1:0] a,
                                              input logic [BW-1:0] b, input logic c);
        logic [BW:0] e;
        case (op)
            0:  e = {1'b0, a} + {1'b0, b} + {8'd0, c};
            1:  e = {1'b0, a} + {1'b0, b} + 9'd1;
            2:  e = {(a >= b), a - b};
            3:  e = {1'b0, a} + {1'b0, ~b} + {8'd0, c};
            4:  e = {1'b0, a & b};
            5:  e = {1'b0, a | b};
            6:  e = {1'b0, ~a};
            7:  e = {1'b0, ~b};
            8:  e = {(a == 8'd0), 8'd0 - a};
            9:  e = {(b == 8'd0), 8'd0 - b};
            10: e = {1'b0, ~a & b};
            11: e = {1'b0, a & ~b};
            12: e = {1'b0, a ^ b};
            13: e = {1'b0, ~(a ^ b)};
            14: e = {1'b0, a};
            default: e = {1'b0, b};
        endcase
        return e;
    endfunction

    task automatic check(input string tag, input int op, input logic [BW-1:0] a,
                         input logic [BW-1:0] b, input logic c);
        logic [BW:0] exp_v;
        @(negedge clk);
        opa = a; opb = b; func_sel = op[3:0]; carry_in = c;
        #1;
        exp_v = expect_of(op, a, b, c);
        tests++;
        if ({carry_out, result} !== exp_v) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%b: got cout=%b f=%h expected cout=%b f=%h",
                     tag, op, a, b, c, carry_out, result, exp_v[BW], exp_v[BW-1:0]);
        end
    endtask

    task automatic sweep(input string tag, input int op);
        for (int i = 0; i < 9; i++)
            for (int j = 0; j < 9; j++)
                for (int c = 0; c < 2; c++)
                    check(tag, op, corner(i), corner(j), c[0]);
    endtask

    task automatic t_initial;
        #1;
        tests++;
        if (result !== 8'h00 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 initial zero inputs: got cout=%b f=%h expected cout=0 f=00",
                     carry_out, result);
        end
    endtask

    task automatic t_add;            sweep("R1", 0); endtask
    task automatic t_add_one;        sweep("R2", 1); endtask
    task automatic t_sub;            sweep("R3", 2); endtask
    task automatic t_sub_borrow;     sweep("R4", 3); endtask
    task automatic t_logic;
        sweep("R5", 4); sweep("R5", 5); sweep("R5", 12); sweep("R5", 13);
    endtask
    task automatic t_masked;         sweep("R6", 10); sweep("R6", 11); endtask
    task automatic t_invert;         sweep("R7", 6);  sweep("R7", 7);  endtask
    task automatic t_negate;         sweep("R8", 8);  sweep("R8", 9);  endtask
    task automatic t_pass;           sweep("R9", 14); sweep("R9", 15); endtask

    // R10: carry_in toggled with all else held; the output must not move.
    task automatic t_cin_ignored;
        logic [BW:0] first;
        for (int op = 1; op < 16; op++) begin
            if (op == 3) continue;
            @(negedge clk);
            opa = 8'hFF; opb = 8'h01; func_sel = op[3:0]; carry_in = 1'b0;
            #1;
            first = {carry_out, result};
            carry_in = 1'b1;
            #1;
            tests++;
            if ({carry_out, result} !== first) begin
                fails++;
                $display("FAIL R10 op=%0d: got %h expected %h", op, {carry_out, result}, first);
            end
        end
    endtask

    // R11: inputs changed twice inside one low clock phase.
    task automatic t_no_state;
        @(negedge clk);
        opa = 8'h10; opb = 8'h20; func_sel = 4'd0; carry_in = 1'b0;
        #1;
        opa = 8'hF0; opb = 8'h20; func_sel = 4'd0;
        #1;
        tests++;
        if ({carry_out, result} !== 9'h110) begin
            fails++;
            $display("FAIL R11 follow without edge: got %h expected 110", {carry_out, result});
        end
        func_sel = 4'd15;
        #1;
        tests++;
        if ({carry_out, result} !== 9'h020) begin
            fails++;
            $display("FAIL R11 select change without edge: got %h expected 020",
                     {carry_out, result});
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        t_initial;
        t_add;
        t_add_one;
        t_sub;
        t_sub_borrow;
        t_logic;
        t_masked;
        t_invert;
        t_negate;
        t_pass;
        t_cin_ignored;
        t_no_state;
        finish_run;
    end

    initial begin
        for (int n = 0; n < WATCHDOG_CYCLES; n++) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run;
    end

endmodule